// File: doc/BRIEF.md
# Fractional UART Baud and Frame Generator

This block turns the three rate and format settings of a UART (line control, integer divisor, fractional adder) into the timing strobes and frame description that the transmit and receive shifters work from. From the reference clock it derives a 16x oversampling strobe and a bit-period strobe. One bit period is 16 times the divisor, plus the low three bits of the fractional value, plus 16 reference clocks. Each bit period therefore has a length that an integer divide alone cannot reach.

The 16 oversampling intervals inside a bit period are not all equal. The first few are one clock longer, as many of them as the fractional value, and the rest last divisor+1 clocks. This keeps every bit period exactly the computed length, with the extra clocks spread through it. The block also decodes the line-control value into the data-bit count, the stop-bit count, the parity enable and sense, the total frame length and the infrared-mode flag. While the divisor is zero the generator stays idle and the decoded format keeps its last value. A one-cycle configuration-write strobe restarts the counters, so a new rate starts from a clean bit boundary.

Top module: `uart_baud_frame_gen`

## Requirements
- R1: With divisor D ≠ 0 and fractional input F, consecutive bit strobes are exactly P = 16·D + F[2:0] + 16 clocks apart. The first bit strobe after a configuration write appears P clocks after the write cycle.
- R2: Each bit period holds exactly 16 oversampling strobes, and the bit strobe coincides with the 16th. Oversampling intervals 0 to F[2:0]−1 last D+2 clocks and the remaining intervals last D+1 clocks.
- R3: Bit 3 of the fractional input has no effect on strobe timing.
- R4: While the divisor is zero, neither strobe is asserted.
- R5: While the divisor is zero, all decoded format outputs hold their previous value whatever the line-control input does.
- R6: The data-bit count output equals line-control bits [1:0] plus 5, giving 5 to 8.
- R7: The two-stop output equals line-control bit 2 (1 = two stop bits, 0 = one).
- R8: The parity-enable output equals line-control bit 5. The parity-even output equals line-control bit 3 when parity is enabled (1 = even, 0 = odd) and is 0 when parity is disabled.
- R9: The frame-length output equals 1 + data bits + parity-enable + stop bits (1 or 2).
- R10: The infrared-mode output equals line-control bit 6.
- R11: A configuration write restarts the generator. No strobe is asserted in the cycle after the write, and timing then follows R1 and R2 from the write.
- R12: After reset both strobes are low and the format outputs show the decode of line-control 0: 5 data bits, one stop bit, no parity, frame length 7, infrared mode off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_ctrl | input | 8 | Line-control setting |
| divisor | input | 16 | Integer rate divisor (0 = idle) |
| frac | input | 4 | Fractional adder (low 3 bits used) |
| cfg_wr | input | 1 | Pulse when any of the three settings is written |
| os_tick | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe |
| data_bits | output | 4 | Decoded data-bit count (5..8) |
| two_stop | output | 1 | Two stop bits selected |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| frame_len | output | 4 | Total frame length in bits |
| ir_mode | output | 1 | Infrared-mode flag |

## Verification
The assertions check on every cycle that the strobes stay quiet while the divisor is zero and right after a configuration write, that a bit strobe never comes without an oversampling strobe, and that two oversampling strobes never fall in consecutive cycles. They also check that the frame length agrees with the other decoded fields, that the format holds while idle, and that the spacing between bit strobes, tracked with a counter, equals P while the settings are stable. Only the bench's scenarios show the exact position of each oversampling strobe inside a period, the exact latency from a write to the first strobe, the independence from the unused fractional bit, and the decode of specific line-control values.

// File: rtl/uart_bfg_pkg.sv
// Shared types and the line-control decode for the baud/frame generator.
// Assumes an 8-bit line-control value; field positions are fixed below.
package uart_bfg_pkg;

    localparam int LC_W       = 8;
    localparam int LC_STOP    = 2;
    localparam int LC_EVEN    = 3;
    localparam int LC_PAR     = 5;
    localparam int LC_IR      = 6;
    localparam int DATA_BASE  = 5;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic [3:0] frame_len;
        logic       ir_mode;
    } frame_fmt_t;

    // Decode a line-control value into the frame description.
    function automatic frame_fmt_t decode_lc(input logic [LC_W-1:0] lc);
        frame_fmt_t f;
        f.data_bits = 4'(lc[1:0]) + 4'(DATA_BASE);
        f.two_stop  = lc[LC_STOP];
        f.par_en    = lc[LC_PAR];
        f.par_even  = lc[LC_PAR] & lc[LC_EVEN];
        f.ir_mode   = lc[LC_IR];
        f.frame_len = 4'd1 + f.data_bits + 4'(f.par_en) + (f.two_stop ? 4'd2 : 4'd1);
        return f;
    endfunction

endpackage

// File: rtl/uart_bfg_fmt_dec.sv
// Frame-format decoder: registers the decoded line-control fields.
// Assumes the generator is idle when divisor_zero is high; the decoded
// fields then hold their last value.
module uart_bfg_fmt_dec
    import uart_bfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LC_W-1:0] line_ctrl,
    input  logic            divisor_zero,
    output frame_fmt_t      fmt
);

    // Capture the decoded format while the generator is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt <= decode_lc('0);
        end else if (!divisor_zero) begin
            fmt <= decode_lc(line_ctrl);
        end
    end

endmodule

// File: rtl/uart_bfg_tick_gen.sv
// Fractional tick generator: OS_RATE oversampling intervals per bit period.
// Interval k lasts divisor+1 clocks, plus one clock when k < frac_used, so a
// bit period is OS_RATE*divisor + frac_used + OS_RATE clocks. Strobes are
// registered. Assumes OS_RATE is a power of two.
module uart_bfg_tick_gen #(
    parameter int DIV_W     = 16,
    parameter int FRAC_USED = 3,
    parameter int OS_RATE   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [DIV_W-1:0]     divisor,
    input  logic [FRAC_USED-1:0] frac_used,
    output logic                 os_tick,
    output logic                 bit_tick
);

    localparam int CNT_W  = DIV_W + 1;
    localparam int SLOT_W = $clog2(OS_RATE);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(OS_RATE - 1);

    logic [CNT_W-1:0]  sub_cnt;
    logic [SLOT_W-1:0] slot;
    logic [CNT_W-1:0]  limit;
    logic              active;
    logic              stretch;

    // Terminal count of the current interval, lengthened for the early slots.
    always_comb begin
        active  = (divisor != '0);
        stretch = (CNT_W'(slot) < CNT_W'(frac_used));
        limit   = CNT_W'(divisor) + CNT_W'(stretch);
    end

    // Interval counter, slot index and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt  <= '0;
            slot     <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else if (restart || !active) begin
            sub_cnt  <= '0;
            slot     <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else if (sub_cnt >= limit) begin
            sub_cnt  <= '0;
            slot     <= slot + 1'b1;
            os_tick  <= 1'b1;
            bit_tick <= (slot == LAST_SLOT);
        end else begin
            sub_cnt  <= sub_cnt + 1'b1;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_baud_frame_gen.sv
// Top of the baud and frame generator: ties the tick generator and the
// format decoder to the configuration inputs. Assumes cfg_wr pulses for one
// cycle whenever line_ctrl, divisor or frac is written.
module uart_baud_frame_gen
    import uart_bfg_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int FRAC_W    = 4,
    parameter int FRAC_USED = 3,
    parameter int OS_RATE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        line_ctrl,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [FRAC_W-1:0] frac,
    input  logic              cfg_wr,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [3:0]        data_bits,
    output logic              two_stop,
    output logic              par_en,
    output logic              par_even,
    output logic [3:0]        frame_len,
    output logic              ir_mode
);

    frame_fmt_t fmt;

    uart_bfg_tick_gen #(
        .DIV_W     (DIV_W),
        .FRAC_USED (FRAC_USED),
        .OS_RATE   (OS_RATE)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cfg_wr),
        .divisor   (divisor),
        .frac_used (frac[FRAC_USED-1:0]),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick)
    );

    uart_bfg_fmt_dec u_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_ctrl    (line_ctrl),
        .divisor_zero (divisor == '0),
        .fmt          (fmt)
    );

    // Fan the decoded format out to the ports.
    always_comb begin
        data_bits = fmt.data_bits;
        two_stop  = fmt.two_stop;
        par_en    = fmt.par_en;
        par_even  = fmt.par_even;
        frame_len = fmt.frame_len;
        ir_mode   = fmt.ir_mode;
    end

endmodule

// File: rtl/uart_bfg_chk.sv
// Assertion checker for uart_baud_frame_gen, attached by bind below.
module uart_bfg_chk #(
    parameter int DIV_W     = 16,
    parameter int FRAC_W    = 4,
    parameter int FRAC_USED = 3,
    parameter int OS_RATE   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        line_ctrl,
    input logic [DIV_W-1:0]  divisor,
    input logic [FRAC_W-1:0] frac,
    input logic              cfg_wr,
    input logic              os_tick,
    input logic              bit_tick,
    input logic [3:0]        data_bits,
    input logic              two_stop,
    input logic              par_en,
    input logic              par_even,
    input logic [3:0]        frame_len,
    input logic              ir_mode
);

    localparam int PW = DIV_W + 8;

    logic [PW-1:0]     gap_cnt;
    logic              gap_valid;
    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    logic [PW-1:0]     period;

    always_comb period = PW'(OS_RATE) * PW'(divisor) + PW'(frac[FRAC_USED-1:0]) + PW'(OS_RATE);

    // Measure the spacing between bit strobes while the settings are stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            gap_valid <= 1'b0;
            div_q     <= '0;
            frac_q    <= '0;
        end else begin
            div_q  <= divisor;
            frac_q <= frac;
            if (cfg_wr || divisor == '0 || divisor != div_q || frac != frac_q) begin
                gap_valid <= 1'b0;
                gap_cnt   <= '0;
            end else if (bit_tick) begin
                // R1
                bit_gap_chk: assert (!gap_valid || gap_cnt == period)
                    else $error("bit strobe spacing %0d, want %0d", gap_cnt, period);
                gap_valid <= 1'b1;
                gap_cnt   <= PW'(1);
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R4
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> !os_tick && !bit_tick);

    // R11
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !os_tick && !bit_tick);

    // R2
    bit_with_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R2
    os_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

    // R9
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len == 4'd1 + data_bits + 4'(par_en) + (two_stop ? 4'd2 : 4'd1));

    // R6
    data_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_bits >= 4'd5 && data_bits <= 4'd8);

    // R8
    even_needs_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_even |-> par_en);

    // R5
    idle_fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> $stable({data_bits, two_stop, par_en, par_even, frame_len, ir_mode}));

endmodule

bind uart_baud_frame_gen uart_bfg_chk #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W), .FRAC_USED(FRAC_USED), .OS_RATE(OS_RATE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl), .divisor(divisor),
    .frac(frac), .cfg_wr(cfg_wr), .os_tick(os_tick), .bit_tick(bit_tick),
    .data_bits(data_bits), .two_stop(two_stop), .par_en(par_en),
    .par_even(par_even), .frame_len(frame_len), .ir_mode(ir_mode)
);

// File: tb/uart_baud_frame_gen_bench.sv
module uart_baud_frame_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_ctrl = '0;
    logic [15:0] divisor = '0;
    logic [3:0]  frac = '0;
    logic        cfg_wr = 1'b0;
    logic        os_tick, bit_tick, two_stop, par_en, par_even, ir_mode;
    logic [3:0]  data_bits, frame_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_baud_frame_gen u_uart_baud_frame_gen (
        .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl), .divisor(divisor),
        .frac(frac), .cfg_wr(cfg_wr), .os_tick(os_tick), .bit_tick(bit_tick),
        .data_bits(data_bits), .two_stop(two_stop), .par_en(par_en),
        .par_even(par_even), .frame_len(frame_len), .ir_mode(ir_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected oversampling strobe at sample n (n=1 is the first sample after the write).
    function automatic bit exp_os(input int n, input int d, input int f, input int p);
        int m = (n - 1) % p;
        int cum = 0;
        if (n < 2) return 1'b0;
        if (m == 0) return 1'b1;
        for (int k = 0; k < 16; k++) begin
            cum += d + 1 + ((k < f) ? 1 : 0);
            if (cum == m) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic pulse_wr();
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check_fmt(input string req, input int db, input bit ts, input bit pe,
                             input bit pv, input int fl, input bit ir);
        check(data_bits == 4'(db), {req, " data_bits"}, int'(data_bits), db);
        check(two_stop == ts, {req, " two_stop"}, int'(two_stop), int'(ts));
        check(par_en == pe, {req, " par_en"}, int'(par_en), int'(pe));
        check(par_even == pv, {req, " par_even"}, int'(par_even), int'(pv));
        check(frame_len == 4'(fl), {req, " frame_len"}, int'(frame_len), fl);
        check(ir_mode == ir, {req, " ir_mode"}, int'(ir_mode), int'(ir));
    endtask

    // R12: state right after reset.
    task automatic t_reset();
        check(os_tick == 1'b0 && bit_tick == 1'b0, "R12 strobes", int'(os_tick), 0);
        check_fmt("R12", 5, 0, 0, 0, 7, 0);
    endtask

    // R1/R2/R3/R11: run two bit periods after a write and compare every sample.
    task automatic t_rate(input int d, input int fr, input string tag);
        int p = 16 * d + (fr & 7) + 16;
        int os_bad = 0, bit_bad = 0, os_cnt = 0, first_bad = -1;
        divisor = 16'(d);
        frac = 4'(fr);
        pulse_wr();
        check(os_tick == 1'b0, {tag, " R11 quiet after write"}, int'(os_tick), 0);
        for (int n = 1; n <= 2 * p + 1; n++) begin
            bit eb = (n == p + 1) || (n == 2 * p + 1);
            if (os_tick != exp_os(n, d, fr & 7, p)) begin
                os_bad++;
                if (first_bad < 0) first_bad = n;
            end
            if (bit_tick != eb) bit_bad++;
            if (os_tick && n > 1 && n <= p + 1) os_cnt++;
            @(negedge clk);
        end
        check(bit_bad == 0, {tag, " R1 bit strobe positions"}, bit_bad, 0);
        check(os_bad == 0, {tag, " R2 oversampling positions"}, first_bad, 0);
        check(os_cnt == 16, {tag, " R2 strobes per period"}, os_cnt, 16);
    endtask

    // R11: a write in mid-period restarts from the write.
    task automatic t_restart();
        divisor = 16'd2;
        frac = 4'd3;
        pulse_wr();
        repeat (23) @(negedge clk);
        t_rate(2, 3, "restart");
    endtask

    // R4/R5: idle while divisor is zero, format frozen.
    task automatic t_idle();
        int ticks = 0;
        line_ctrl = 8'h00;
        divisor = 16'd1;
        @(negedge clk);
        divisor = 16'd0;
        pulse_wr();
        line_ctrl = 8'h7F;
        for (int n = 0; n < 120; n++) begin
            if (os_tick || bit_tick) ticks++;
            @(negedge clk);
        end
        check(ticks == 0, "R4 no strobes while idle", ticks, 0);
        check_fmt("R5 hold", 5, 0, 0, 0, 7, 0);
    endtask

    // R6-R10: decode of several line-control values.
    task automatic t_fmt(input logic [7:0] lc, input string req, input int db,
                         input bit ts, input bit pe, input bit pv, input int fl, input bit ir);
        divisor = 16'd1;
        line_ctrl = lc;
        @(negedge clk);
        check_fmt(req, db, ts, pe, pv, fl, ir);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rate(2, 0, "d2f0");
        t_rate(3, 5, "d3f5");
        t_rate(3, 13, "R3 d3f13");
        t_rate(1, 7, "d1f7");
        t_restart();
        t_idle();
        t_fmt(8'h3F, "R6 R7 R8 R9 lc3F", 8, 1, 1, 1, 12, 0);
        t_fmt(8'h21, "R8 R9 odd lc21", 6, 0, 1, 0, 9, 0);
        t_fmt(8'h0A, "R8 even-without-parity lc0A", 7, 0, 0, 0, 9, 0);
        t_fmt(8'h44, "R10 R7 lc44", 5, 1, 0, 0, 8, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule